// File: doc/BRIEF.md
# Modem Control-Line Handshake Controller

This block is the modem-side sequencer for the control-line handshake between a modem and an attached terminal. It drives three active-low indications to the terminal: set ready (`dsr_n`), carrier detect (`dcd_n`) and clear to send (`cts_n`). It watches two active-low requests from the terminal, terminal ready (`dtr_n`) and request to send (`rts_n`). It also takes an active-high link-lock flag from the data path and an active-high power-good flag.

The terminal inputs and the lock flag may be asynchronous and may have slow edges. The power-good flag is treated the same way. All four pass through a bank of `SYNC_STAGES` flip-flop synchronisers, two by default, before the state machine sees them. The controller is held off by any of three conditions: a synchronous active-low reset, an active-low hold pin, or the reset code `3'b001` on the three-bit mode bus. The hold pin is expected to idle high at board level. While held off, every output is inactive.

The state machine has four states. IDLE drives nothing. READY asserts set-ready. LOCKED adds carrier detect. CLEAR adds clear-to-send. The transitions are:
- IDLE→READY when power is good.
- READY→LOCKED when lock is present and the terminal is ready.
- LOCKED→CLEAR when send is requested.
- CLEAR→LOCKED when the request is withdrawn.
- LOCKED or CLEAR→READY when lock or terminal-ready is lost.
- Any state→IDLE when power drops or the block is held off.

Top module: `modem_ctl_handshake`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `dsr_n`, `dcd_n` and `cts_n` are all high in the following cycle and the sequence restarts from IDLE.
- R2: A value of `3'b001` on `mode_sel` acts exactly like reset. Any other `mode_sel` value has no effect on the outputs.
- R3: `halt_n` held low acts exactly like reset.
- R4: `dsr_n` goes low on the third rising edge after `pwr_ready` rises. When `pwr_ready` falls, all three outputs go high on the third edge. `dcd_n` is never low while `dsr_n` is high.
- R5: With `dsr_n` low, `dcd_n` goes low on the third edge after both `lock_in` is high and `dtr_n` is low.
- R6: When `dtr_n` goes high, `dcd_n` and `cts_n` both go high on the same edge, the third after the change, while `dsr_n` stays low.
- R7: `cts_n` goes low in response to `rts_n` low only while `dcd_n` is low. `cts_n` is never low while `dcd_n` is high. `cts_n` never falls on the edge where `dcd_n` falls, so simultaneous requests give `dcd_n` low on edge 3 and `cts_n` low on edge 4.
- R8: When `rts_n` returns high, `cts_n` goes high on the third edge while `dcd_n` stays low.
- R9: When `lock_in` falls, `dcd_n` and `cts_n` both go high on the same edge, the third after the change, while `dsr_n` stays low.
- R10: Each of `pwr_ready`, `dtr_n`, `rts_n` and `lock_in` is seen through a two-stage synchroniser, so no output responds to it before the third rising edge after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_n | input | 1 | Hold-off pin, active low, idles high |
| mode_sel | input | 3 | Mode bus; code 3'b001 holds the block off |
| pwr_ready | input | 1 | Modem powered and ready, active high |
| dtr_n | input | 1 | Terminal ready, active low, asynchronous |
| rts_n | input | 1 | Request to send, active low, asynchronous |
| lock_in | input | 1 | Link synchronisation lock, active high, asynchronous |
| dsr_n | output | 1 | Set ready to terminal, active low |
| dcd_n | output | 1 | Carrier detect to terminal, active low |
| cts_n | output | 1 | Clear to send to terminal, active low |

## Verification
Directed sequences bring the link up one input at a time and also with all requests at once. The simultaneous case separates a design that lets clear-to-send follow carrier detect by one edge from one that asserts both together.

Each bring-up is then torn down separately by request withdrawal, lock loss, terminal drop and power loss. This tells apart the single-output release (request withdrawal) from the paired release (lock loss or terminal drop) and the full release (power loss).

A long constrained-random phase biases inputs toward the fully connected state. It injects rare resets, hold pulses and arbitrary mode codes, so the bench can tell the one reset code apart from neighbouring values. A cycle-level expectation model exposes any wrong synchroniser depth.

// File: rtl/mdm_hs_pkg.sv
package mdm_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READY  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_CLEAR  = 2'd3
    } hs_state_e;

    // Bit positions inside the synchroniser bank
    localparam int SB_PWR   = 0;
    localparam int SB_TERM  = 1;
    localparam int SB_SEND  = 2;
    localparam int SB_LOCK  = 3;
    localparam int SB_WIDTH = 4;

endpackage

// File: rtl/mdm_sync_bank.sv
module mdm_sync_bank #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             hold,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (hold) stage_q[0] <= '0;
                    else      stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (hold) stage_q[s] <= '0;
                    else      stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/mdm_hold_gen.sv
module mdm_hold_gen #(
    parameter int               MODE_W     = 3,
    parameter logic [MODE_W-1:0] RESET_CODE = 3'b001
) (
    input  logic              rst_n,
    input  logic              halt_n,
    input  logic [MODE_W-1:0] mode_sel,
    output logic              hold
);

    logic code_hit;

    always_comb begin
        code_hit = (mode_sel == RESET_CODE);
        hold     = !rst_n || !halt_n || code_hit;
    end

endmodule

// File: rtl/mdm_hs_fsm.sv
module mdm_hs_fsm
    import mdm_hs_pkg::*;
(
    input  logic clk,
    input  logic hold,
    input  logic pwr_ok,
    input  logic term_ready,
    input  logic send_req,
    input  logic link_up,
    output logic dsr_n,
    output logic dcd_n,
    output logic cts_n
);

    hs_state_e state_q, state_d;
    logic      carrier_ok;

    assign carrier_ok = link_up && term_ready;

    // State register
    always_ff @(posedge clk) begin
        if (hold) state_q <= ST_IDLE;
        else      state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_ok) state_d = ST_READY;
            end
            ST_READY: begin
                if (!pwr_ok)         state_d = ST_IDLE;
                else if (carrier_ok) state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (!pwr_ok)          state_d = ST_IDLE;
                else if (!carrier_ok) state_d = ST_READY;
                else if (send_req)    state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (!pwr_ok)          state_d = ST_IDLE;
                else if (!carrier_ok) state_d = ST_READY;
                else if (!send_req)   state_d = ST_LOCKED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        dsr_n = 1'b1;
        dcd_n = 1'b1;
        cts_n = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_READY: begin
                dsr_n = 1'b0;
            end
            ST_LOCKED: begin
                dsr_n = 1'b0;
                dcd_n = 1'b0;
            end
            ST_CLEAR: begin
                dsr_n = 1'b0;
                dcd_n = 1'b0;
                cts_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/modem_ctl_handshake.sv
module modem_ctl_handshake
    import mdm_hs_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                MODE_W      = 3,
    parameter logic [MODE_W-1:0] RESET_CODE  = 3'b001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              pwr_ready,
    input  logic              dtr_n,
    input  logic              rts_n,
    input  logic              lock_in,
    output logic              dsr_n,
    output logic              dcd_n,
    output logic              cts_n
);

    logic                hold;
    logic [SB_WIDTH-1:0] raw_vec;
    logic [SB_WIDTH-1:0] syn_vec;

    mdm_hold_gen #(
        .MODE_W     (MODE_W),
        .RESET_CODE (RESET_CODE)
    ) u_hold (
        .rst_n    (rst_n),
        .halt_n   (halt_n),
        .mode_sel (mode_sel),
        .hold     (hold)
    );

    // Inputs are converted to active-high before synchronising
    always_comb begin
        raw_vec          = '0;
        raw_vec[SB_PWR]  = pwr_ready;
        raw_vec[SB_TERM] = !dtr_n;
        raw_vec[SB_SEND] = !rts_n;
        raw_vec[SB_LOCK] = lock_in;
    end

    mdm_sync_bank #(
        .WIDTH  (SB_WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .hold     (hold),
        .async_in (raw_vec),
        .sync_out (syn_vec)
    );

    mdm_hs_fsm u_fsm (
        .clk        (clk),
        .hold       (hold),
        .pwr_ok     (syn_vec[SB_PWR]),
        .term_ready (syn_vec[SB_TERM]),
        .send_req   (syn_vec[SB_SEND]),
        .link_up    (syn_vec[SB_LOCK]),
        .dsr_n      (dsr_n),
        .dcd_n      (dcd_n),
        .cts_n      (cts_n)
    );

endmodule

// File: rtl/mdm_hs_checker.sv
module mdm_hs_checker #(
    parameter int                MODE_W     = 3,
    parameter logic [MODE_W-1:0] RESET_CODE = 3'b001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt_n,
    input logic [MODE_W-1:0] mode_sel,
    input logic              dsr_n,
    input logic              dcd_n,
    input logic              cts_n
);

    logic off_now;
    assign off_now = !rst_n || !halt_n || (mode_sel == RESET_CODE);

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> (dsr_n && dcd_n && cts_n)); // R1

    AST_CODE_QUIET: assert property (@(posedge clk)
        (rst_n && mode_sel == RESET_CODE) |=> (dsr_n && dcd_n && cts_n)); // R2

    AST_HALT_QUIET: assert property (@(posedge clk)
        (rst_n && !halt_n) |=> (dsr_n && dcd_n && cts_n)); // R3

    AST_DCD_NEEDS_DSR: assert property (@(posedge clk) disable iff (off_now)
        !dcd_n |-> !dsr_n); // R4

    AST_CTS_NEEDS_DCD: assert property (@(posedge clk) disable iff (off_now)
        !cts_n |-> !dcd_n); // R7

    AST_CTS_AFTER_DCD: assert property (@(posedge clk) disable iff (off_now)
        $fell(dcd_n) |-> cts_n); // R7

    AST_CARRIER_DROP_PAIR: assert property (@(posedge clk) disable iff (off_now)
        ($rose(dcd_n) && !dsr_n) |-> cts_n); // R9

endmodule

bind modem_ctl_handshake mdm_hs_checker #(
    .MODE_W     (MODE_W),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_n   (halt_n),
    .mode_sel (mode_sel),
    .dsr_n    (dsr_n),
    .dcd_n    (dcd_n),
    .cts_n    (cts_n)
);

// File: tb/modem_ctl_handshake_tb.sv
`timescale 1ns/1ps
module modem_ctl_handshake_tb;

    logic       clk = 1'b0;
    logic       rst_n, halt_n, pwr_ready, dtr_n, rts_n, lock_in;
    logic [2:0] mode_sel;
    logic       dsr_n, dcd_n, cts_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    modem_ctl_handshake u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_n    (halt_n),
        .mode_sel  (mode_sel),
        .pwr_ready (pwr_ready),
        .dtr_n     (dtr_n),
        .rts_n     (rts_n),
        .lock_in   (lock_in),
        .dsr_n     (dsr_n),
        .dcd_n     (dcd_n),
        .cts_n     (cts_n)
    );

    // Expectation model built from the requirements: 2-edge input delay,
    // then one edge for the state update.
    logic [3:0] m_d1 = '0, m_d2 = '0;  // {lock, send, term, pwr}
    int         m_st = 0;              // 0 idle,1 ready,2 locked,3 clear

    function automatic bit off_cond(logic r, logic h, logic [2:0] m);
        return !r || !h || (m == 3'b001);
    endfunction

    function automatic int step_model(int st, logic [3:0] s);
        bit pw  = s[0];
        bit car = s[1] && s[3];
        if (!pw) return 0;
        case (st)
            0: return 1;
            1: return car ? 2 : 1;
            2: return !car ? 1 : (s[2] ? 3 : 2);
            default: return !car ? 1 : (!s[2] ? 2 : 3);
        endcase
    endfunction

    always @(posedge clk) begin
        if (off_cond(rst_n, halt_n, mode_sel)) begin
            m_d1 <= '0; m_d2 <= '0; m_st <= 0;
        end else begin
            m_d1 <= {lock_in, !rts_n, !dtr_n, pwr_ready};
            m_d2 <= m_d1;
            m_st <= step_model(m_st, m_d2);
        end
    end

    task automatic chk(bit ok, string req, string what, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic expect_out(string req, logic e_dsr, logic e_dcd, logic e_cts);
        chk({dsr_n, dcd_n, cts_n} == {e_dsr, e_dcd, e_cts}, req, "dsr/dcd/cts",
            {dsr_n, dcd_n, cts_n}, {e_dsr, e_dcd, e_cts});
    endtask

    // Per-cycle comparison against the model, plus the CTS/DCD invariant
    bit model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on) begin
            chk(dsr_n == (m_st == 0), "R4", "model dsr_n",
                {2'b0, dsr_n}, {2'b0, 1'(m_st == 0)});
            chk(dcd_n == (m_st < 2), "R5", "model dcd_n",
                {2'b0, dcd_n}, {2'b0, 1'(m_st < 2)});
            chk(cts_n == (m_st < 3), "R8", "model cts_n",
                {2'b0, cts_n}, {2'b0, 1'(m_st < 3)});
            chk(!( !cts_n && dcd_n), "R7", "cts low with dcd high",
                {1'b0, dcd_n, cts_n}, 3'b011);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; halt_n = 1; mode_sel = 3'b000;
        pwr_ready = 0; dtr_n = 1; rts_n = 1; lock_in = 0;
        cyc(3);
        expect_out("R1", 1, 1, 1);
        model_on = 1'b1;
        rst_n = 1;

        // Power-up: two edges nothing, third edge set-ready (R4, R10)
        pwr_ready = 1;
        cyc(2); expect_out("R10", 1, 1, 1);
        cyc(1); expect_out("R4", 0, 1, 1);

        // All requests at once: DCD on edge 3, CTS on edge 4 (R5, R7)
        dtr_n = 0; lock_in = 1; rts_n = 0;
        cyc(2); expect_out("R10", 0, 1, 1);
        cyc(1); expect_out("R5", 0, 0, 1);
        cyc(1); expect_out("R7", 0, 0, 0);

        // Withdraw request (R8)
        rts_n = 1;
        cyc(2); expect_out("R8", 0, 0, 0);
        cyc(1); expect_out("R8", 0, 0, 1);

        // Lock loss releases DCD and CTS together (R9)
        rts_n = 0; cyc(4); expect_out("R7", 0, 0, 0);
        lock_in = 0;
        cyc(2); expect_out("R9", 0, 0, 0);
        cyc(1); expect_out("R9", 0, 1, 1);

        // RTS alone without carrier gives no CTS (R7)
        cyc(4); expect_out("R7", 0, 1, 1);

        // Terminal drop (R6)
        lock_in = 1; cyc(5); expect_out("R5", 0, 0, 0);
        dtr_n = 1;
        cyc(2); expect_out("R6", 0, 0, 0);
        cyc(1); expect_out("R6", 0, 1, 1);

        // Mode code reset, and a neighbouring code with no effect (R2)
        dtr_n = 0; cyc(5); expect_out("R2", 0, 0, 0);
        mode_sel = 3'b011; cyc(3); expect_out("R2", 0, 0, 0);
        mode_sel = 3'b001; cyc(1); expect_out("R2", 1, 1, 1);
        cyc(2); expect_out("R2", 1, 1, 1);
        mode_sel = 3'b000; cyc(6); expect_out("R2", 0, 0, 0);

        // Hold pin (R3)
        halt_n = 0; cyc(1); expect_out("R3", 1, 1, 1);
        halt_n = 1; cyc(6); expect_out("R3", 0, 0, 0);

        // Power loss drops everything (R4)
        pwr_ready = 0;
        cyc(2); expect_out("R4", 0, 0, 0);
        cyc(1); expect_out("R4", 1, 1, 1);
        pwr_ready = 1; cyc(6); expect_out("R4", 0, 0, 0);

        // Reset mid-session (R1)
        rst_n = 0; cyc(1); expect_out("R1", 1, 1, 1);
        rst_n = 1;

        // Constrained random phase checked by the model
        for (int i = 0; i < 4000; i++) begin
            pwr_ready = ($urandom % 32) != 0;
            dtr_n     = ($urandom % 12) == 0;
            lock_in   = ($urandom % 10) != 0;
            rts_n     = ($urandom % 2) == 0;
            rst_n     = ($urandom % 128) != 0;
            halt_n    = ($urandom % 128) != 0;
            mode_sel  = (($urandom % 16) == 0) ? 3'($urandom) : 3'b000;
            cyc(1 + ($urandom % 4));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule